// File: doc/BRIEF.md
# Event-Driven Latched Output Controller

This block turns a small set of hardware event flags into two indicator outputs that need no software to react. The events are four general-purpose input assertions and three monitor flags: a voltage out of range, a thermal limit and a fan failure. Each output has its own 8-bit mask register. A 0 in a mask bit lets that event drive the output, and a 1 ignores it. An output asserts when any of its unmasked events is present.

A configuration register holds one latch bit and one polarity bit for each output. With latching off, the output follows the events one clock later. With latching on, the first event holds the output asserted until software writes a clear strobe. The polarity bit sets whether the asserted pin level is high or low.

Software programs the block through a plain single-cycle register port. The comparators that produce the monitor flags sit outside the block.

Top module: `evo_ctrl`

## Requirements
- R1: Each output n (n = 0, 1) has its own mask register at address n. Software can write it and read it back through `reg_rdata`.
- R2: Mask and event bit positions are: bit 7 = voltage out of range, bit 6 = thermal limit, bit 5 = fan failure, bit 3 = general input 4, bit 2 = input 3, bit 1 = input 2, bit 0 = input 1.
- R3: Mask bit 4 is reserved. It always reads as 0, and writing it has no effect on any output.
- R4: A mask bit of 0 lets its event drive the output and a mask bit of 1 ignores it. An output asserts on the OR of its unmasked events.
- R5: With latching off, the output reflects the event state sampled at the previous rising clock edge: one register stage and no earlier change.
- R6: With latching on, an output that has asserted stays asserted after all of its events have gone away.
- R7: Writing address 3 with bit n set is a clear strobe for latched output n. The strobe deasserts that output only if none of its unmasked events is present, and it leaves the other output alone. Address 3 reads as 0.
- R8: A polarity bit of 1 makes the output pin high when asserted. A polarity bit of 0 makes the pin low when asserted.
- R9: After reset both masks ignore every event and read 0xEF, the configuration reads 0, and both pins sit at their deasserted level (high).
- R10: The configuration register is at address 2. Its layout is bit 0 = latch for output 0, bit 1 = latch for output 1, bit 2 = polarity for output 0, bit 3 = polarity for output 1, and bits 7..4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| gpio_evt | input | 4 | General input events, bit 0 = input 1 |
| mon_volt | input | 1 | Voltage out of range flag |
| mon_therm | input | 1 | Thermal limit flag |
| mon_fan | input | 1 | Fan failure flag |
| evt_pin | output | 2 | Output pins, bit n = output n |

## Verification
Each event is first applied alone, with only its own mask bit cleared. This shows the event reaches the right output through the right bit position. All other events are then applied together under the same mask, which shows that masked events cannot leak through. A one-cycle pulse on a following output, compared with the same pulse on a latched output, separates follow mode from hold mode. Clear strobes are issued with an event still present, to the wrong output, and finally under the proper conditions, which separates a blocked clear from a misrouted clear and from an effective one. Polarity changes while an output is held show that only the pin level changes and the asserted state is kept.

// File: rtl/evo_pkg.sv
package evo_pkg;
  localparam int unsigned EVW     = 8;
  localparam int unsigned B_VOLT  = 7;
  localparam int unsigned B_THERM = 6;
  localparam int unsigned B_FAN   = 5;
  localparam int unsigned B_RSVD  = 4;
  localparam int unsigned MAX_GPIO = 4;

  typedef logic [EVW-1:0] evmask_t;

  typedef struct packed {
    logic volt;
    logic therm;
    logic fan;
  } mon_t;

  localparam evmask_t MASK_RESET = ~(evmask_t'(1) << B_RSVD);
endpackage

// File: rtl/evo_regs.sv
module evo_regs
  import evo_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [EVW-1:0]              wdata,
  output logic [EVW-1:0]              rdata,
  output logic [NUM_OUT-1:0][EVW-1:0] mask_q,
  output logic [NUM_OUT-1:0]          latch_q,
  output logic [NUM_OUT-1:0]          pol_q,
  output logic [NUM_OUT-1:0]          clr_o
);
  localparam int unsigned A_CFG = NUM_OUT;
  localparam int unsigned A_CLR = NUM_OUT + 1;

  logic [NUM_OUT-1:0][EVW-1:0] mask_d;
  logic [NUM_OUT-1:0]          latch_d;
  logic [NUM_OUT-1:0]          pol_d;
  logic                        cfg_wr;
  logic                        clr_wr;

  assign cfg_wr = we && (addr == ADDR_W'(A_CFG));
  assign clr_wr = we && (addr == ADDR_W'(A_CLR));

  // next state
  always_comb begin
    mask_d  = mask_q;
    latch_d = latch_q;
    pol_d   = pol_q;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (we && (addr == ADDR_W'(i))) begin
        mask_d[i]         = wdata;
        mask_d[i][B_RSVD] = 1'b0;
      end
    end
    if (cfg_wr) begin
      latch_d = wdata[NUM_OUT-1:0];
      pol_d   = wdata[2*NUM_OUT-1:NUM_OUT];
    end
  end

  assign clr_o = clr_wr ? wdata[NUM_OUT-1:0] : '0;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OUT; i++) mask_q[i] <= MASK_RESET;
      latch_q <= '0;
      pol_q   <= '0;
    end else begin
      mask_q  <= mask_d;
      latch_q <= latch_d;
      pol_q   <= pol_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (addr == ADDR_W'(i)) rdata = mask_q[i];
    end
    if (addr == ADDR_W'(A_CFG)) begin
      rdata[NUM_OUT-1:0]         = latch_q;
      rdata[2*NUM_OUT-1:NUM_OUT] = pol_q;
    end
  end
endmodule

// File: rtl/evo_combine.sv
module evo_combine
  import evo_pkg::*;
#(
  parameter int unsigned NUM_GPIO = 4
) (
  input  logic [NUM_GPIO-1:0] gpio,
  input  mon_t                mon,
  input  logic [EVW-1:0]      mask,
  output logic                hit
);
  logic [EVW-1:0] evt_vec;

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_VOLT]  = mon.volt;
    evt_vec[B_THERM] = mon.therm;
    evt_vec[B_FAN]   = mon.fan;
    for (int i = 0; i < NUM_GPIO; i++) evt_vec[i] = gpio[i];
  end

  assign hit = |(evt_vec & ~mask);
endmodule

// File: rtl/evo_chan.sv
module evo_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_en,
  input  logic pol,
  input  logic hit,
  input  logic clr,
  output logic act_q,
  output logic pin
);
  logic act_d;

  always_comb begin
    if (latch_en) act_d = hit | (act_q & ~clr);
    else          act_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign pin = pol ? act_q : ~act_q;
endmodule

// File: rtl/evo_ctrl.sv
module evo_ctrl
  import evo_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 2,
  parameter int unsigned NUM_GPIO = 4,
  parameter int unsigned ADDR_W   = $clog2(NUM_OUT + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [EVW-1:0]      reg_wdata,
  output logic [EVW-1:0]      reg_rdata,
  input  logic [NUM_GPIO-1:0] gpio_evt,
  input  logic                mon_volt,
  input  logic                mon_therm,
  input  logic                mon_fan,
  output logic [NUM_OUT-1:0]  evt_pin
);
  logic [1:0]                  rst_sync;
  logic                        rst_q_n;
  logic [NUM_OUT-1:0][EVW-1:0] mask_v;
  logic [NUM_OUT-1:0]          latch_v;
  logic [NUM_OUT-1:0]          pol_v;
  logic [NUM_OUT-1:0]          clr_v;
  logic [NUM_OUT-1:0]          hit_v;
  logic [NUM_OUT-1:0]          act_v;
  mon_t                        mon;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign mon = '{volt: mon_volt, therm: mon_therm, fan: mon_fan};

  evo_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .mask_q (mask_v),
    .latch_q(latch_v),
    .pol_q  (pol_v),
    .clr_o  (clr_v)
  );

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    evo_combine #(.NUM_GPIO(NUM_GPIO)) comb_i (
      .gpio(gpio_evt),
      .mon (mon),
      .mask(mask_v[n]),
      .hit (hit_v[n])
    );
    evo_chan chan_i (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .latch_en(latch_v[n]),
      .pol     (pol_v[n]),
      .hit     (hit_v[n]),
      .clr     (clr_v[n]),
      .act_q   (act_v[n]),
      .pin     (evt_pin[n])
    );
  end
endmodule

// File: rtl/evo_ctrl_chk.sv
module evo_ctrl_chk
  import evo_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned ADDR_W  = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [EVW-1:0]              reg_rdata,
  input logic [NUM_OUT-1:0][EVW-1:0] mask,
  input logic [NUM_OUT-1:0]          latch,
  input logic [NUM_OUT-1:0]          clr,
  input logic [NUM_OUT-1:0]          hit,
  input logic [NUM_OUT-1:0]          act
);
  // R3: reserved mask bit never reads as 1
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(NUM_OUT)) |-> !reg_rdata[B_RSVD]);

  // R7: clear-strobe address reads as 0
  a_r7_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(NUM_OUT + 1)) |-> (reg_rdata == '0));

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_chk
    // R4: an output whose events are all ignored does not assert
    a_r4_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[n] == MASK_RESET && !latch[n]) |=> !act[n]);
    // R5: follow mode tracks the event OR one cycle later
    a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(latch[n]) |-> (act[n] == $past(hit[n])));
    // R6: latched state holds without a clear
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(latch[n]) && $past(act[n]) && !$past(clr[n])) |-> act[n]);
    // R7: a present event blocks the clear
    a_r7_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(latch[n]) && $past(hit[n])) |-> act[n]);
  end
endmodule

bind evo_ctrl evo_ctrl_chk #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .mask     (mask_v),
  .latch    (latch_v),
  .clr      (clr_v),
  .hit      (hit_v),
  .act      (act_v)
);

// File: tb/evo_ctrl_tb_top.sv
module evo_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] gpio_evt;
  logic       mon_volt, mon_therm, mon_fan;
  logic [1:0] evt_pin;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  evo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_evt(gpio_evt),
    .mon_volt(mon_volt), .mon_therm(mon_therm), .mon_fan(mon_fan),
    .evt_pin(evt_pin)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // event byte: [7] volt [6] therm [5] fan [3:0] gpio4..1
  task automatic set_evt(logic [7:0] e);
    gpio_evt = e[3:0]; mon_fan = e[5]; mon_therm = e[6]; mon_volt = e[7];
  endtask

  task automatic t_reset();
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; set_evt(8'h00);
    repeat (3) step();
    chk("R9 pins in reset", {6'd0, evt_pin}, 8'h03);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R9 pins after reset", {6'd0, evt_pin}, 8'h03);
    rd_chk("R9 mask0 reset", 2'd0, 8'hEF);
    rd_chk("R9 mask1 reset", 2'd1, 8'hEF);
    rd_chk("R10 cfg reset", 2'd2, 8'h00);
    rd_chk("R7 clear addr reads 0", 2'd3, 8'h00);
  endtask

  task automatic t_regs();
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h3C);
    rd_chk("R1 mask0 readback", 2'd0, 8'h4A);
    rd_chk("R1 mask1 readback", 2'd1, 8'h2C);
    wr(2'd2, 8'hFF);
    rd_chk("R10 cfg upper bits 0", 2'd2, 8'h0F);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    rd_chk("R3 rsvd reads 0", 2'd0, 8'hEF);
  endtask

  task automatic t_bits();
    for (int k = 0; k < 8; k++) begin
      if (k == 4) continue;
      wr(2'd0, ~(8'h01 << k));
      set_evt(8'h01 << k);
      step();
      chk($sformatf("R2 R4 event bit %0d drives out0", k), {6'd0, evt_pin}, 8'h02);
      set_evt(~(8'h01 << k));
      step();
      chk($sformatf("R4 others masked bit %0d", k), {6'd0, evt_pin}, 8'h03);
      set_evt(8'h00);
      step();
    end
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_reserved();
    wr(2'd0, 8'h10);
    rd_chk("R3 rsvd-only write reads 0", 2'd0, 8'h00);
    set_evt(8'h01);
    step();
    chk("R3 rsvd bit no effect", {6'd0, evt_pin}, 8'h02);
    set_evt(8'h00);
    step();
    chk("R3 idle deasserted", {6'd0, evt_pin}, 8'h03);
    wr(2'd0, 8'hFF);
  endtask

  task automatic t_follow();
    wr(2'd0, 8'hF0);
    set_evt(8'h02);
    #1;
    chk("R5 no change before edge", {6'd0, evt_pin}, 8'h03);
    step();
    chk("R5 asserted after edge", {6'd0, evt_pin}, 8'h02);
    set_evt(8'h00);
    step();
    chk("R5 follows release", {6'd0, evt_pin}, 8'h03);
  endtask

  task automatic t_latch();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h7F);
    set_evt(8'h80);
    step();
    chk("R6 latch sets", {6'd0, evt_pin}, 8'h02);
    set_evt(8'h00);
    step();
    chk("R6 holds 1", {6'd0, evt_pin}, 8'h02);
    repeat (3) step();
    chk("R6 holds 4", {6'd0, evt_pin}, 8'h02);
  endtask

  task automatic t_clear();
    set_evt(8'h80);
    wr(2'd3, 8'h01);
    chk("R7 clear blocked by event", {6'd0, evt_pin}, 8'h02);
    set_evt(8'h00);
    step();
    wr(2'd3, 8'h02);
    chk("R7 other-output clear ignored", {6'd0, evt_pin}, 8'h02);
    wr(2'd3, 8'h01);
    chk("R7 clear takes effect", {6'd0, evt_pin}, 8'h03);
    step();
    chk("R7 stays clear", {6'd0, evt_pin}, 8'h03);
  endtask

  task automatic t_polarity();
    wr(2'd2, 8'h0C);
    chk("R8 active-high idle", {6'd0, evt_pin}, 8'h00);
    wr(2'd1, 8'hBF);
    set_evt(8'h40);
    step();
    chk("R8 out1 high when asserted", {6'd0, evt_pin}, 8'h02);
    wr(2'd2, 8'h04);
    chk("R8 out1 low when asserted", {6'd0, evt_pin}, 8'h00);
    rd_chk("R10 cfg readback", 2'd2, 8'h04);
    set_evt(8'h00);
    step();
    chk("R8 out1 idle high", {6'd0, evt_pin}, 8'h02);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_bits();
    t_reserved();
    t_follow();
    t_latch();
    t_clear();
    t_polarity();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule